// File: doc/BRIEF.md
# CPU Bus Region Decoder with Wait-State Acknowledge

This block sits on the address and control lines of a 16-bit, 68000-style processor bus. It turns a strobed access into active-low chip selects and byte-lane strobes for three memory regions: a main program ROM, an expansion port, and a system ROM. It also produces the data-transfer acknowledge after a number of processor clocks that depends on the region, the direction of the access and a few wait-configuration pins.

The block runs from the master clock and divides it by two to make the processor clock. It passes out a remapped copy of the two top address lines. When the vector-swap input is high, accesses to the lowest kilobyte of the address space are steered into the system ROM region, so the exception vectors can come from either ROM. The memories and the register that sets the swap input are outside the block.

Top module: `cpu_region_decoder`

## Requirements
- R1: A read with address strobe low and byte address in 0x000000..0x0FFFFF (after remapping) drives `main_rd_no` low, `main_rdu_no` equal to `uds_ni` and `main_rdl_no` equal to `lds_ni`. A write to this region drives none of the three low.
- R2: Any access with address strobe low in 0x200000..0x2FFFFF drives `port_any_no` low. On reads (`rw_i`=1) `port_rdu_no`/`port_rdl_no` follow `uds_ni`/`lds_ni`. On writes (`rw_i`=0) `port_wru_no`/`port_wrl_no` follow them.
- R3: A read with address strobe low in 0xC00000..0xCFFFFF (after remapping) drives `sys_rd_no` low, and `sys_rdu_no`/`sys_rdl_no` follow `uds_ni`/`lds_ni`.
- R4: With `as_ni` high, or with any address outside the three regions, every strobe stays high and `dtack_no` stays high.
- R5: When `vec_swap_i`=1 and the byte address is below 0x000400, `a23_remap_o`/`a22_remap_o` are 1/1 and the access decodes as system ROM. In every other case they equal address bits 23 and 22.
- R6: The first processor tick that samples `as_ni` low in a decoded region loads the wait count W. `dtack_no` falls at that tick when W=0, or W ticks later otherwise. Each region also has its own base wait parameter.
- R7: A main ROM read with `rom_wait_ni` low adds exactly one tick to W. On writes the pin has no effect.
- R8: An expansion port read adds {~`port_wait_ni`[1], ~`port_wait_ni`[0]} (0..3) ticks to W. Expansion port writes add nothing.
- R9: `dtack_no` returns high in the same cycle that `as_ni` goes high, with no clock edge in between.
- R10: `cpu_clk_o` is 0 in reset and toggles on every master clock edge. A processor tick is a master edge at which `cpu_clk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 23 | Word address, byte address bits 23..1 |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper (even) byte strobe, active low |
| lds_ni | input | 1 | Lower (odd) byte strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| vec_swap_i | input | 1 | Steer vector fetches to the system ROM |
| rom_wait_ni | input | 1 | One extra wait on main ROM reads, active low |
| port_wait_ni | input | 2 | Extra waits on expansion reads, active low code |
| cpu_clk_o | output | 1 | Processor clock, master divided by two |
| a22_remap_o | output | 1 | Remapped address bit 22 |
| a23_remap_o | output | 1 | Remapped address bit 23 |
| main_rd_no | output | 1 | Main ROM read, combined |
| main_rdu_no | output | 1 | Main ROM even byte read |
| main_rdl_no | output | 1 | Main ROM odd byte read |
| port_any_no | output | 1 | Expansion port any access |
| port_rdu_no | output | 1 | Expansion even byte read |
| port_rdl_no | output | 1 | Expansion odd byte read |
| port_wru_no | output | 1 | Expansion even byte write |
| port_wrl_no | output | 1 | Expansion odd byte write |
| sys_rd_no | output | 1 | System ROM read, combined |
| sys_rdu_no | output | 1 | System ROM even byte read |
| sys_rdl_no | output | 1 | System ROM odd byte read |
| dtack_no | output | 1 | Data-transfer acknowledge, active low |

## Verification
The timer assertions assume the address, direction and wait pins stay fixed while the address strobe is low. This matches the processor's bus protocol, and it means the wait count taken at the first tick still describes the access when the acknowledge appears. The bench keeps to this: it changes the address and control inputs only while the strobe is high, and it holds each access long enough for the longest wait before it releases the strobe. The assertions also assume the strobe goes high between accesses, and every bench access ends with at least two idle master cycles.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_MAIN = 2'd1,
        REG_PORT = 2'd2,
        REG_SYS  = 2'd3
    } region_e;

    // Top address nibble (bits 23..20) that selects each region
    localparam logic [3:0] MAIN_NIB = 4'h0;
    localparam logic [3:0] PORT_NIB = 4'h2;
    localparam logic [3:0] SYS_NIB  = 4'hC;

endpackage

// File: rtl/cpu_clk_div.sv
module cpu_clk_div (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= 1'b0;
        else         phase_q <= phase_d;
    end

    assign tick_o = phase_q;

    p_toggle_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_q |=> !phase_q);
    p_toggle_lo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_q |=> phase_q);
endmodule

// File: rtl/vec_remap.sv
module vec_remap #(
    parameter int unsigned VEC_LSB = 10
) (
    input  logic [23:VEC_LSB] addr_hi_i,
    input  logic              swap_i,
    output logic              a22_o,
    output logic              a23_o
);
    logic in_window;

    always_comb begin
        in_window = (addr_hi_i == '0);
        if (swap_i && in_window) begin
            a23_o = 1'b1;
            a22_o = 1'b1;
        end else begin
            a23_o = addr_hi_i[23];
            a22_o = addr_hi_i[22];
        end
    end
endmodule

// File: rtl/region_strobe.sv
module region_strobe
    import busdec_pkg::*;
(
    input  logic [3:0] nib_i,
    input  logic       as_ni,
    input  logic       uds_ni,
    input  logic       lds_ni,
    input  logic       rw_i,
    output region_e    region_o,
    output logic       main_rd_no,
    output logic       main_rdu_no,
    output logic       main_rdl_no,
    output logic       port_any_no,
    output logic       port_rdu_no,
    output logic       port_rdl_no,
    output logic       port_wru_no,
    output logic       port_wrl_no,
    output logic       sys_rd_no,
    output logic       sys_rdu_no,
    output logic       sys_rdl_no
);
    logic rd, wr;

    always_comb begin
        unique case (nib_i)
            MAIN_NIB: region_o = REG_MAIN;
            PORT_NIB: region_o = REG_PORT;
            SYS_NIB:  region_o = REG_SYS;
            default:  region_o = REG_NONE;
        endcase

        rd = !as_ni &&  rw_i;
        wr = !as_ni && !rw_i;

        main_rd_no  = 1'b1;
        main_rdu_no = 1'b1;
        main_rdl_no = 1'b1;
        port_any_no = 1'b1;
        port_rdu_no = 1'b1;
        port_rdl_no = 1'b1;
        port_wru_no = 1'b1;
        port_wrl_no = 1'b1;
        sys_rd_no   = 1'b1;
        sys_rdu_no  = 1'b1;
        sys_rdl_no  = 1'b1;

        case (region_o)
            REG_MAIN: if (rd) begin
                main_rd_no  = 1'b0;
                main_rdu_no = uds_ni;
                main_rdl_no = lds_ni;
            end
            REG_PORT: begin
                port_any_no = as_ni;
                if (rd) begin
                    port_rdu_no = uds_ni;
                    port_rdl_no = lds_ni;
                end
                if (wr) begin
                    port_wru_no = uds_ni;
                    port_wrl_no = lds_ni;
                end
            end
            REG_SYS: if (rd) begin
                sys_rd_no  = 1'b0;
                sys_rdu_no = uds_ni;
                sys_rdl_no = lds_ni;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ack_timer.sv
module ack_timer
    import busdec_pkg::*;
#(
    parameter int unsigned MAIN_WAIT = 0,
    parameter int unsigned PORT_WAIT = 0,
    parameter int unsigned SYS_WAIT  = 0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       as_ni,
    input  logic       rw_i,
    input  region_e    region_i,
    input  logic       rom_wait_ni,
    input  logic [1:0] port_wait_ni,
    output logic       dtack_no
);
    localparam int unsigned MAX_BASE_A = (MAIN_WAIT > PORT_WAIT) ? MAIN_WAIT : PORT_WAIT;
    localparam int unsigned MAX_BASE   = (MAX_BASE_A > SYS_WAIT) ? MAX_BASE_A : SYS_WAIT;
    localparam int unsigned MAX_WAIT   = MAX_BASE + 3;
    localparam int unsigned CNT_W      = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             ack;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] wait_sel;
    logic             rom_extra;
    logic [1:0]       port_extra;

    always_comb begin
        rom_extra  = rw_i && !rom_wait_ni;
        port_extra = rw_i ? ~port_wait_ni : 2'b00;
        case (region_i)
            REG_MAIN: wait_sel = CNT_W'(MAIN_WAIT) + CNT_W'(rom_extra);
            REG_PORT: wait_sel = CNT_W'(PORT_WAIT) + CNT_W'(port_extra);
            REG_SYS:  wait_sel = CNT_W'(SYS_WAIT);
            default:  wait_sel = '0;
        endcase

        st_d = st_q;
        if (as_ni) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.ack    = 1'b0;
        end else if (tick_i) begin
            if (!st_q.active) begin
                if (region_i != REG_NONE) begin
                    st_d.active = 1'b1;
                    st_d.cnt    = wait_sel;
                    st_d.ack    = (wait_sel == '0);
                end
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.ack = (st_q.cnt == CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dtack_no = ~(st_q.ack & ~as_ni);

    p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_ni |=> !st_q.ack);
    p_zero_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !as_ni && !st_q.active && region_i != REG_NONE && wait_sel == '0)
        |=> st_q.ack);
    p_unmapped_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!as_ni && !st_q.active && region_i == REG_NONE) |=> !st_q.ack);
    p_hold_between_ticks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && !as_ni && !tick_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/cpu_region_decoder.sv
module cpu_region_decoder
    import busdec_pkg::*;
#(
    parameter int unsigned MAIN_WAIT = 0,
    parameter int unsigned PORT_WAIT = 0,
    parameter int unsigned SYS_WAIT  = 0,
    parameter int unsigned VEC_BYTES = 1024
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [23:1] addr_i,
    input  logic        as_ni,
    input  logic        uds_ni,
    input  logic        lds_ni,
    input  logic        rw_i,
    input  logic        vec_swap_i,
    input  logic        rom_wait_ni,
    input  logic [1:0]  port_wait_ni,
    output logic        cpu_clk_o,
    output logic        a22_remap_o,
    output logic        a23_remap_o,
    output logic        main_rd_no,
    output logic        main_rdu_no,
    output logic        main_rdl_no,
    output logic        port_any_no,
    output logic        port_rdu_no,
    output logic        port_rdl_no,
    output logic        port_wru_no,
    output logic        port_wrl_no,
    output logic        sys_rd_no,
    output logic        sys_rdu_no,
    output logic        sys_rdl_no,
    output logic        dtack_no
);
    localparam int unsigned VEC_LSB = $clog2(VEC_BYTES);

    logic    tick;
    region_e region;
    logic    unused_addr_bits;

    assign unused_addr_bits = ^addr_i[VEC_LSB-1:1];

    cpu_clk_div u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );
    assign cpu_clk_o = tick;

    vec_remap #(.VEC_LSB(VEC_LSB)) u_remap (
        .addr_hi_i (addr_i[23:VEC_LSB]),
        .swap_i    (vec_swap_i),
        .a22_o     (a22_remap_o),
        .a23_o     (a23_remap_o)
    );

    region_strobe u_dec (
        .nib_i       ({a23_remap_o, a22_remap_o, addr_i[21:20]}),
        .as_ni       (as_ni),
        .uds_ni      (uds_ni),
        .lds_ni      (lds_ni),
        .rw_i        (rw_i),
        .region_o    (region),
        .main_rd_no  (main_rd_no),
        .main_rdu_no (main_rdu_no),
        .main_rdl_no (main_rdl_no),
        .port_any_no (port_any_no),
        .port_rdu_no (port_rdu_no),
        .port_rdl_no (port_rdl_no),
        .port_wru_no (port_wru_no),
        .port_wrl_no (port_wrl_no),
        .sys_rd_no   (sys_rd_no),
        .sys_rdu_no  (sys_rdu_no),
        .sys_rdl_no  (sys_rdl_no)
    );

    ack_timer #(
        .MAIN_WAIT (MAIN_WAIT),
        .PORT_WAIT (PORT_WAIT),
        .SYS_WAIT  (SYS_WAIT)
    ) u_ack (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .as_ni        (as_ni),
        .rw_i         (rw_i),
        .region_i     (region),
        .rom_wait_ni  (rom_wait_ni),
        .port_wait_ni (port_wait_ni),
        .dtack_no     (dtack_no)
    );

    p_one_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({~main_rd_no, ~port_any_no, ~sys_rd_no}));
    p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_ni |-> (dtack_no && main_rd_no && port_any_no && sys_rd_no
                   && port_wru_no && port_wrl_no));
    p_swap_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_swap_i |-> (a23_remap_o == addr_i[23] && a22_remap_o == addr_i[22]));
    p_swap_force_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_swap_i && addr_i[23:VEC_LSB] == '0) |-> (a23_remap_o && a22_remap_o));
endmodule

// File: tb/sim_cpu_region_decoder.sv
module sim_cpu_region_decoder;
    localparam int SYS_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] b_addr = 24'h0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic        swap = 1'b0, romw_n = 1'b1;
    logic [1:0]  pw_n = 2'b11;
    logic        cpu_clk, a22r, a23r, dtack_n;
    logic [10:0] strb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_region_decoder #(.SYS_WAIT(SYS_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr[23:1]), .as_ni(as_n),
        .uds_ni(uds_n), .lds_ni(lds_n), .rw_i(rw), .vec_swap_i(swap),
        .rom_wait_ni(romw_n), .port_wait_ni(pw_n), .cpu_clk_o(cpu_clk),
        .a22_remap_o(a22r), .a23_remap_o(a23r),
        .main_rd_no(strb[10]), .main_rdu_no(strb[9]), .main_rdl_no(strb[8]),
        .port_any_no(strb[7]), .port_rdu_no(strb[6]), .port_rdl_no(strb[5]),
        .port_wru_no(strb[4]), .port_wrl_no(strb[3]),
        .sys_rd_no(strb[2]), .sys_rdu_no(strb[1]), .sys_rdl_no(strb[0]),
        .dtack_no(dtack_n));

    // behavioural reference state
    int m_phase = 0, m_act = 0, m_cnt = 0, m_ack = 0;

    function automatic bit vec_hit();
        return swap && (b_addr < 24'h000400);
    endfunction

    // 0 none, 1 main, 2 port, 3 system
    function automatic int which_region();
        if (vec_hit()) return 3;
        if (b_addr <= 24'h0FFFFF) return 1;
        if (b_addr >= 24'h200000 && b_addr <= 24'h2FFFFF) return 2;
        if (b_addr >= 24'hC00000 && b_addr <= 24'hCFFFFF) return 3;
        return 0;
    endfunction

    function automatic int wait_for_access();
        case (which_region())
            1: return (rw && !romw_n) ? 1 : 0;
            2: return rw ? (3 - int'(pw_n)) : 0;
            3: return SYS_W;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_act = 0; m_cnt = 0; m_ack = 0;
        end else begin
            if (as_n) begin
                m_act = 0; m_ack = 0; m_cnt = 0;
            end else if (m_phase == 1) begin
                if (m_act == 0) begin
                    if (which_region() != 0) begin
                        m_act = 1;
                        m_cnt = wait_for_access();
                        m_ack = (m_cnt == 0);
                    end
                end else if (m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_ack = 1;
                end
            end
            m_phase = 1 - m_phase;
        end
    end

    function automatic logic [10:0] exp_strobes();
        logic [10:0] e = '1;
        if (!as_n) begin
            case (which_region())
                1: if (rw) begin e[10] = 0; e[9] = uds_n; e[8] = lds_n; end
                2: begin
                    e[7] = 0;
                    if (rw) begin e[6] = uds_n; e[5] = lds_n; end
                    else    begin e[4] = uds_n; e[3] = lds_n; end
                end
                3: if (rw) begin e[2] = 0; e[1] = uds_n; e[0] = lds_n; end
                default: ;
            endcase
        end
        return e;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!done) begin
            string stag, dtag;
            logic [1:0] er;
            int rg;
            rg = which_region();
            case (rg)
                1: stag = "R1 main strobes";
                2: stag = "R2 port strobes";
                3: stag = "R3 sys strobes";
                default: stag = "R4 no strobes";
            endcase
            if (as_n) stag = "R4 idle strobes";
            chk(stag, int'(strb), int'(exp_strobes()));
            er = vec_hit() ? 2'b11 : b_addr[23:22];
            chk("R5 remap", int'({a23r, a22r}), int'(er));
            if (as_n)                          dtag = "R9 dtack release";
            else if (rg == 0)                  dtag = "R4 dtack unmapped";
            else if (rg == 1 && rw && !romw_n) dtag = "R7 dtack rom wait";
            else if (rg == 2 && rw)            dtag = "R8 dtack port wait";
            else                               dtag = "R6 dtack timing";
            chk(dtag, int'(dtack_n), (m_ack != 0 && !as_n) ? 0 : 1);
            chk("R10 cpu clock", int'(cpu_clk), m_phase);
        end
    end

    task automatic access(input logic [23:0] a, input logic r, input logic u,
                          input logic l, input logic sw, input logic rw_n,
                          input logic [1:0] p, input int hold);
        @(negedge clk);
        b_addr = a; rw = r; uds_n = u; lds_n = l; swap = sw; romw_n = rw_n; pw_n = p;
        @(negedge clk);
        as_n = 1'b0;
        repeat (hold) @(negedge clk);
        as_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: all strobes idle, ack high, clock low
        chk("R4 reset strobes", int'(strb), 2047);
        chk("R10 reset clock", int'(cpu_clk), 0);
        rst_n = 1'b1;
        // main ROM (R1, R6, R7)
        access(24'h000100, 1, 0, 0, 0, 1, 2'b11, 12);
        access(24'h000100, 1, 0, 1, 0, 0, 2'b11, 12);
        access(24'h0FFFFE, 1, 1, 0, 0, 0, 2'b11, 12);
        access(24'h040000, 0, 0, 0, 0, 0, 2'b11, 12); // write: R7 pin ignored
        // expansion port reads, all wait codes (R2, R8)
        for (int k = 0; k < 4; k++)
            access(24'h200010, 1, 0, 0, 0, 1, 2'(k), 14);
        access(24'h2FFFFE, 1, 1, 0, 0, 1, 2'b00, 14);
        access(24'h200020, 0, 0, 1, 0, 1, 2'b00, 12);
        access(24'h200022, 0, 1, 0, 0, 1, 2'b01, 12);
        // system ROM with base waits (R3, R6)
        access(24'hC00000, 1, 0, 0, 0, 1, 2'b11, 12);
        access(24'hCFFFFE, 1, 0, 1, 0, 1, 2'b11, 12);
        access(24'hC80000, 0, 0, 0, 0, 1, 2'b11, 12);
        // unmapped (R4)
        access(24'h100000, 1, 0, 0, 0, 1, 2'b11, 10);
        access(24'h1FFFFE, 0, 0, 0, 0, 1, 2'b11, 10);
        access(24'hD00000, 1, 0, 0, 0, 1, 2'b11, 10);
        access(24'h400000, 1, 0, 0, 0, 1, 2'b11, 10);
        // vector swap (R5)
        access(24'h000008, 1, 0, 0, 1, 1, 2'b11, 12);
        access(24'h0003FE, 1, 0, 0, 1, 1, 2'b11, 12);
        access(24'h000400, 1, 0, 0, 1, 1, 2'b11, 12);
        access(24'h000008, 1, 0, 0, 0, 1, 2'b11, 12);
        access(24'hC00004, 1, 0, 0, 1, 1, 2'b11, 12);
        // short strobe pulse: release before ack (R9)
        access(24'hC00000, 1, 0, 0, 0, 1, 2'b11, 2);
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule